// File: doc/BRIEF.md
# Banked Real-Time Clock Register File

This block is the host-facing register store of a real-time clock that sits on a multiplexed byte bus. It holds the eight time and calendar bytes, three alarm bytes, two main control registers, a nonvolatile user RAM and a small extended region with a read-only identity area and two extended control registers. The counting engine lives outside. Each second it presents the next time in binary on `cnt_time`. It raises `cnt_pre` one cycle before the carry and pulses `cnt_carry` when the carry happens.

One bit of the first control register picks the bank for the upper half of the address space. Bank 0 maps that half to more user RAM. Bank 1 maps it to the identity bytes and the extended control registers. A host that wants a coherent view of the time sets the freeze bit in the second control register. While frozen, carries no longer reach the time bytes and the host may rewrite them. Two read-only flags show the host when a carry is close: update-in-progress in the first control register and the increment flag in extended register A. The data-mode bit chooses whether loaded time bytes are stored as BCD or as binary.

Top module: `rtc_regfile`

## Requirements
- R1: After synchronous reset the time bytes, alarm bytes, both main control registers, extended register B and `bus_rdata` are all zero, so bank 0 and BCD mode are selected.
- R2: A read strobe in a cycle returns that cycle's register contents on `bus_rdata` after the next clock edge. `bus_rdata` holds its value in cycles with no strobe.
- R3: Addresses 0x10–0x3F are user RAM in both banks. Addresses 0x40–0x7F are further user RAM while control A bit 4 (bank select) is 0. Extended register B (bank 1, 0x49) is read/write.
- R4: In bank 1, address 0x40+k (k = 0..7) returns bits 8k+7:8k of the identity parameter, which is loaded at reset. Writes there are ignored.
- R5: In bank 1, addresses 0x4A–0x7F read as zero. Bank-1 writes to them, or to the identity bytes, leave the bank-0 RAM at the same addresses unchanged.
- R6: Address k (0..7) holds time byte k, which is bits 8k+7:8k of `time_q`. With control B bit 7 (freeze) at 1, carries leave the time bytes unchanged and host writes to them take effect. With freeze at 0, host writes to them are ignored and a carry loads them.
- R7: On a carry, control B bit 2 (data mode) at 1 stores each `cnt_time` byte unchanged (binary). At 0 it stores the BCD form of that byte (values 0–99).
- R8: Extended register A (bank 1, 0x48) reads bit 6 as 1 exactly when `cnt_pre` is high at the read strobe. Only bits 5, 3, 2, 1 and 0 are writable. Bits 7 and 4 read 0.
- R9: Control A (0x0B) bit 7 reads 1 when `cnt_pre` or `cnt_carry` is high at the strobe, and host writes do not set it. Bits 6–0 are read/write.
- R10: Alarm bytes at 0x08–0x0A (bits 8k+7:8k of `alarm_q` for address 8+k) can be read and written whatever the freeze state, and carries never change them.
- R11: Addresses 0x0D–0x0F read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_pre | input | 1 | Carry expected next cycle |
| cnt_carry | input | 1 | Once-per-second carry pulse |
| cnt_time | input | 64 | Next time from the counter, binary, byte k = field k |
| time_q | output | 64 | Stored time bytes |
| alarm_q | output | 24 | Stored alarm bytes |
| ctrl_b_q | output | 8 | Control B (freeze, data mode and enables) |

## Verification
The bench sweeps every counter value from 0 to 99 through the BCD conversion on all eight fields. A converter with a bad tens digit would therefore show up as a wrong byte on readback. It fills every RAM byte, then writes all-ones across bank 1. A decoder that let bank-1 writes through to RAM, or let RAM show through the identity area, would corrupt the bank-0 readback. It carries while frozen, writes the time while not frozen, and checks that the increment flag and the update-in-progress flag follow `cnt_pre` and ignore host writes. A register that latched either flag would read back a stale 1.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

    localparam int IDX_W  = 8;
    localparam int NFIELD = 8;

    localparam logic [IDX_W-1:0] A_ALARM0 = 8'h08;
    localparam logic [IDX_W-1:0] A_CTLA   = 8'h0B;
    localparam logic [IDX_W-1:0] A_CTLB   = 8'h0C;
    localparam logic [IDX_W-1:0] X_EXTA   = 8'h08;
    localparam logic [IDX_W-1:0] X_EXTB   = 8'h09;

    localparam int CB_FREEZE = 7;
    localparam int CB_DM     = 2;
    localparam int CA_UIP    = 7;
    localparam int CA_BANK   = 4;
    localparam int XA_INCR   = 6;
    localparam logic [7:0] XA_WMASK = 8'h2F;

    typedef enum logic [3:0] {
        RG_NONE, RG_TIME, RG_ALARM, RG_CTLA, RG_CTLB,
        RG_RAM, RG_ID, RG_EXTA, RG_EXTB
    } rg_kind_e;

    typedef struct packed {
        rg_kind_e         kind;
        logic [IDX_W-1:0] idx;
    } rg_hit_t;

    function automatic logic [7:0] to_bcd(input logic [7:0] v);
        return {4'(v / 8'd10), 4'(v % 8'd10)};
    endfunction

endpackage

// File: rtl/rtc_bank_decode.sv
module rtc_bank_decode
    import rtc_regfile_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int RAM_BASE = 16,
    parameter int EXT_BASE = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    output rg_hit_t           hit
);
    localparam logic [IDX_W-1:0] RB = IDX_W'(RAM_BASE);
    localparam logic [IDX_W-1:0] XB = IDX_W'(EXT_BASE);

    logic [IDX_W-1:0] a;

    always_comb begin
        a        = IDX_W'(addr);
        hit.kind = RG_NONE;
        hit.idx  = a;
        if (a < A_ALARM0) begin
            hit.kind = RG_TIME;
        end else if (a < A_CTLA) begin
            hit.kind = RG_ALARM;
            hit.idx  = a - A_ALARM0;
        end else if (a == A_CTLA) begin
            hit.kind = RG_CTLA;
        end else if (a == A_CTLB) begin
            hit.kind = RG_CTLB;
        end else if (a < RB) begin
            hit.kind = RG_NONE;
        end else if (a < XB || !bank) begin
            hit.kind = RG_RAM;
            hit.idx  = a - RB;
        end else if (a - XB < X_EXTA) begin
            hit.kind = RG_ID;
            hit.idx  = a - XB;
        end else if (a - XB == X_EXTA) begin
            hit.kind = RG_EXTA;
        end else if (a - XB == X_EXTB) begin
            hit.kind = RG_EXTB;
        end
    end
endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
    import rtc_regfile_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [2:0]            host_idx,
    input  logic [7:0]            host_data,
    input  logic                  carry,
    input  logic                  freeze,
    input  logic                  bin_mode,
    input  logic [NF*8-1:0]       next_time,
    output logic [NF*8-1:0]       time_q
);
    for (genvar g = 0; g < NF; g++) begin : g_field
        logic [7:0] nb;
        assign nb = next_time[g*8 +: 8];
        always_ff @(posedge clk) begin
            if (rst) begin
                time_q[g*8 +: 8] <= '0;
            end else if (freeze) begin
                if (host_we && host_idx == 3'(g))
                    time_q[g*8 +: 8] <= host_data;
            end else if (carry) begin
                time_q[g*8 +: 8] <= bin_mode ? nb : to_bcd(nb);
            end
        end
    end
endmodule

// File: rtl/rtc_nv_ram.sv
module rtc_nv_ram #(
    parameter int DEPTH = 112,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter int          RAM_BASE = 16,
    parameter int          EXT_BASE = 64,
    parameter logic [63:0] ID_BYTES = 64'h5A0F1E2D3C4B6987
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cnt_pre,
    input  logic              cnt_carry,
    input  logic [63:0]       cnt_time,
    output logic [63:0]       time_q,
    output logic [23:0]       alarm_q,
    output logic [7:0]        ctrl_b_q
);
    localparam int RAM_DEPTH = (2 ** ADDR_W) - RAM_BASE;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);

    rg_hit_t     hit;
    logic [6:0]  ctrl_a_q;
    logic [7:0]  ext_a_q;
    logic [7:0]  ext_b_q;
    logic [63:0] id_q;
    logic [7:0]  ram_rd;
    logic [7:0]  rd_val;
    logic        uip;

    rtc_bank_decode #(
        .ADDR_W  (ADDR_W),
        .RAM_BASE(RAM_BASE),
        .EXT_BASE(EXT_BASE)
    ) u_dec (
        .addr(bus_addr),
        .bank(ctrl_a_q[CA_BANK]),
        .hit (hit)
    );

    rtc_time_bank #(.NF(NFIELD)) u_time (
        .clk      (clk),
        .rst      (rst),
        .host_we  (bus_wr && hit.kind == RG_TIME),
        .host_idx (hit.idx[2:0]),
        .host_data(bus_wdata),
        .carry    (cnt_carry),
        .freeze   (ctrl_b_q[CB_FREEZE]),
        .bin_mode (ctrl_b_q[CB_DM]),
        .next_time(cnt_time),
        .time_q   (time_q)
    );

    rtc_nv_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
        .clk  (clk),
        .we   (bus_wr && hit.kind == RG_RAM),
        .idx  (RAM_AW'(hit.idx)),
        .wdata(bus_wdata),
        .rdata(ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
            ext_a_q  <= '0;
            ext_b_q  <= '0;
            alarm_q  <= '0;
            id_q     <= ID_BYTES;
        end else if (bus_wr) begin
            unique case (hit.kind)
                RG_CTLA:  ctrl_a_q <= bus_wdata[6:0];
                RG_CTLB:  ctrl_b_q <= bus_wdata;
                RG_EXTA:  ext_a_q  <= bus_wdata & XA_WMASK;
                RG_EXTB:  ext_b_q  <= bus_wdata;
                RG_ALARM: alarm_q[{hit.idx[1:0], 3'b000} +: 8] <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign uip = cnt_pre || cnt_carry;

    always_comb begin
        rd_val = '0;
        unique case (hit.kind)
            RG_TIME:  rd_val = time_q[{hit.idx[2:0], 3'b000} +: 8];
            RG_ALARM: rd_val = alarm_q[{hit.idx[1:0], 3'b000} +: 8];
            RG_CTLA:  rd_val = {uip, ctrl_a_q};
            RG_CTLB:  rd_val = ctrl_b_q;
            RG_RAM:   rd_val = ram_rd;
            RG_ID:    rd_val = id_q[{hit.idx[2:0], 3'b000} +: 8];
            RG_EXTA: begin
                rd_val          = ext_a_q & XA_WMASK;
                rd_val[XA_INCR] = cnt_pre;
            end
            RG_EXTB:  rd_val = ext_b_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              cnt_carry,
    input logic [63:0]       cnt_time,
    input logic [63:0]       time_q,
    input logic [23:0]       alarm_q,
    input logic [7:0]        ctrl_b_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (time_q == '0 && alarm_q == '0 && ctrl_b_q == '0 && bus_rdata == '0));

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_frozen_time_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_b_q[7] && !(bus_wr && bus_addr < ADDR_W'(8))) |=> $stable(time_q));

    assert_idle_time_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_b_q[7] && !cnt_carry) |=> $stable(time_q));

    assert_binary_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_b_q[7] && ctrl_b_q[2] && cnt_carry) |=> time_q == $past(cnt_time));

    assert_alarm_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(alarm_q));
endmodule

bind rtc_regfile rtc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .cnt_carry(cnt_carry),
    .cnt_time (cnt_time),
    .time_q   (time_q),
    .alarm_q  (alarm_q),
    .ctrl_b_q (ctrl_b_q)
);

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb;
    localparam logic [63:0] ID = 64'h5A0F1E2D3C4B6987;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cnt_pre = 1'b0;
    logic        cnt_carry = 1'b0;
    logic [63:0] cnt_time = '0;
    logic [63:0] time_q;
    logic [23:0] alarm_q;
    logic [7:0]  ctrl_b_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    rtc_regfile #(.ID_BYTES(ID)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_pre(cnt_pre), .cnt_carry(cnt_carry), .cnt_time(cnt_time),
        .time_q(time_q), .alarm_q(alarm_q), .ctrl_b_q(ctrl_b_q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic carry(input logic [63:0] t);
        @(negedge clk);
        cnt_time = t; cnt_carry = 1'b1;
        @(negedge clk);
        cnt_carry = 1'b0;
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 00 expected 01");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        rd(7'h00, got); check("R1 time0", got, 8'h00);
        rd(7'h0B, got); check("R1 ctrlA", got, 8'h00);
        rd(7'h0C, got); check("R1 ctrlB", got, 8'h00);
        rd(7'h08, got); check("R1 alarm", got, 8'h00);

        // R3 RAM sweep in bank 0
        for (int a = 16; a < 128; a++) wr(7'(a), pat(a));
        for (int a = 16; a < 128; a++) begin
            rd(7'(a), got); check("R3 ram bank0", got, pat(a));
        end

        // bank 1: identity, reserved, overlap
        wr(7'h0B, 8'h10);
        for (int k = 0; k < 8; k++) begin
            rd(7'(64 + k), got); check("R4 id", got, ID[k*8 +: 8]);
        end
        for (int a = 74; a < 128; a++) begin
            rd(7'(a), got); check("R5 reserved bank1", got, 8'h00);
        end
        for (int a = 64; a < 72; a++) wr(7'(a), 8'hFF);
        for (int a = 74; a < 128; a++) wr(7'(a), 8'hFF);
        for (int k = 0; k < 8; k++) begin
            rd(7'(64 + k), got); check("R4 id after write", got, ID[k*8 +: 8]);
        end
        for (int a = 16; a < 64; a++) begin
            rd(7'(a), got); check("R3 low ram bank1", got, pat(a));
        end

        // R8 increment flag and writable mask
        wr(7'h48, 8'hFF);
        rd(7'h48, got); check("R8 extA idle", got, 8'h2F);
        cnt_pre = 1'b1;
        rd(7'h48, got); check("R8 extA incr", got, 8'h6F);
        // R9 update in progress while cnt_pre high
        rd(7'h0B, got); check("R9 uip", got, 8'h90);
        cnt_pre = 1'b0;
        rd(7'h48, got); check("R8 extA clear", got, 8'h2F);
        wr(7'h49, 8'hA5);
        rd(7'h49, got); check("R3 extB", got, 8'hA5);

        wr(7'h0B, 8'h00);
        for (int a = 64; a < 128; a++) begin
            rd(7'(a), got); check("R5 bank0 intact", got, pat(a));
        end

        // R9 write to UIP ignored
        wr(7'h0B, 8'hEF);
        rd(7'h0B, got); check("R9 uip not writable", got, 8'h6F);
        wr(7'h0B, 8'h00);

        // R7 BCD sweep, all fields
        wr(7'h0C, 8'h00);
        for (int v = 0; v < 100; v++) begin
            logic [63:0] t;
            for (int k = 0; k < 8; k++) t[k*8 +: 8] = 8'((v + k * 13) % 100);
            carry(t);
            for (int k = 0; k < 8; k++) begin
                rd(7'(k), got); check("R7 bcd", got, bcd((v + k * 13) % 100));
            end
        end

        // R7 binary mode
        wr(7'h0C, 8'h04);
        for (int v = 0; v < 100; v += 7) begin
            logic [63:0] t;
            for (int k = 0; k < 8; k++) t[k*8 +: 8] = 8'((v + k * 11) % 100);
            carry(t);
            for (int k = 0; k < 8; k++) begin
                rd(7'(k), got); check("R7 binary", got, 8'((v + k * 11) % 100));
            end
        end

        // R6 host write ignored while not frozen
        carry(64'h0706050403020100);
        wr(7'h00, 8'h55);
        rd(7'h00, got); check("R6 write ignored", got, 8'h00);

        // R6 frozen: host writes land, carry blocked
        wr(7'h0C, 8'h84);
        for (int k = 0; k < 8; k++) wr(7'(k), 8'(16 + k));
        carry(64'h1111111111111111);
        for (int k = 0; k < 8; k++) begin
            rd(7'(k), got); check("R6 frozen", got, 8'(16 + k));
        end
        check("R6 time_q", time_q[7:0], 8'h10);
        wr(7'h0C, 8'h04);
        carry(64'h2222222222222222);
        rd(7'h03, got); check("R6 resumed", got, 8'h22);

        // R10 alarms
        for (int k = 0; k < 3; k++) wr(7'(8 + k), 8'(8'hC0 + k));
        carry(64'h3333333333333333);
        for (int k = 0; k < 3; k++) begin
            rd(7'(8 + k), got); check("R10 alarm", got, 8'(8'hC0 + k));
        end
        check("R10 alarm_q", alarm_q[23:16], 8'hC2);

        // R11 reserved low addresses
        for (int a = 13; a < 16; a++) wr(7'(a), 8'hFF);
        for (int a = 13; a < 16; a++) begin
            rd(7'(a), got); check("R11 reserved", got, 8'h00);
        end

        // R2 hold without strobe
        rd(7'h09, got);
        wr(7'h09, 8'h3C);
        repeat (3) @(negedge clk);
        check("R2 hold", bus_rdata, 8'hC1);
        rd(7'h09, got); check("R2 new read", got, 8'h3C);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule